// File: doc/BRIEF.md
# Size-Aware Add/Subtract Flag Unit

This block is the arithmetic core of an integer datapath that works on byte, word and long-word operands held in 32-bit registers. It adds, subtracts, or adds with the extend flag as carry-in, and produces a 32-bit result and five condition flags: extend, negative, zero, overflow and carry. For a byte or word operation only the low 8 or 16 bits are computed. The upper bits of the destination pass through to the result unchanged, so the result can be written straight back to the destination register.

The carry is taken from the carry-out at the top of the selected size: bit 7, 15 or 31. For subtraction the carry reports a borrow. The extend flag is loaded from the new carry only when the caller asserts the update control. Otherwise it keeps the value presented on the extend input. Inputs are sampled on every rising clock edge, and the result and flags appear on registered outputs one cycle later.

Top module: `szflag_alu`

## Requirements
- R1: Op code 0 (add) gives dst + src, truncated to the selected size, in the low result bits.
- R2: Op code 1 (subtract) gives dst - src, truncated to the selected size. Carry (bit 0 of the flag output) is 1 exactly when the unsigned sized src is greater than the unsigned sized dst (a borrow).
- R3: Op code 2 (add with extend) gives dst + src + x_in, truncated to the selected size.
- R4: Size code 0 is byte (8 bits), 1 is word (16 bits) and 2 is long (32 bits). For add and add with extend, carry is the carry-out of bit 7, 15 or 31 respectively.
- R5: When x_update is 1, flag bit 4 (extend) equals the new carry flag bit 0.
- R6: When x_update is 0, flag bit 4 equals x_in, whatever the operation produces.
- R7: For byte size, result[31:8] equals dst[31:8]. For word size, result[31:16] equals dst[31:16].
- R8: Flag bit 3 (negative) equals the most significant bit of the sized result.
- R9: Flag bit 2 (zero) is 1 exactly when every bit of the sized result is 0.
- R10: Flag bit 1 (overflow) is 1 exactly when the signed sized operation overflows.
- R11: Result and flags are registered and reflect the inputs sampled at the previous rising edge. While rst_n is low, both read as zero.
- R12: Op code 3 behaves as add, and size code 3 behaves as long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | 0 add, 1 subtract, 2 add with extend, 3 add |
| size_sel | input | 2 | 0 byte, 1 word, 2 long, 3 long |
| src_opnd | input | 32 | Source operand |
| dst_opnd | input | 32 | Destination operand; its upper bits pass through for short sizes |
| x_in | input | 1 | Current extend flag |
| x_update | input | 1 | Load the extend flag from the new carry |
| result | output | 32 | Merged result, registered |
| ccr_out | output | 5 | Flags {X,N,Z,V,C}, bit 4 down to bit 0, registered |

## Verification
Two functions can act in the same cycle: the size-dependent carry-out and the extend hold/update choice. A single operation can produce a carry at the size boundary while x_update is low, so carry and extend must disagree. The same operation must also keep its carry out of the preserved upper destination bits. The bench provokes this with byte and word sums that overflow their field, such as 0xFF + 0x01 on a destination whose upper bits are nonzero. It runs each sum twice, with x_update high and then low, and judges the result bits, the carry, and the extend bit separately against a reference model computed from the requirements.

// File: rtl/szalu_pkg.sv
`timescale 1ns/1ps
package szalu_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANE_W = 8;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_ADDX = 2'd2,
        OP_RSVD = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } alu_sz_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;
endpackage

// File: rtl/szalu_lane_adder.sv
`timescale 1ns/1ps
module szalu_lane_adder #(
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 8
) (
    input  logic [DW-1:0]    a_in,
    input  logic [DW-1:0]    b_in,
    input  logic             c_in,
    output logic [DW-1:0]    sum,
    output logic [DW/LW-1:0] lane_cout
);
    localparam int unsigned LANES = DW / LW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic          ci;
        logic [LW:0]   part;
        if (i == 0) begin : g_first
            assign ci = c_in;
        end else begin : g_chain
            assign ci = g_lane[i-1].part[LW];
        end
        assign part = {1'b0, a_in[i*LW +: LW]} + {1'b0, b_in[i*LW +: LW]} + {{LW{1'b0}}, ci};
        assign sum[i*LW +: LW] = part[LW-1:0];
        assign lane_cout[i]    = part[LW];
    end
endmodule

// File: rtl/szalu_flags.sv
`timescale 1ns/1ps
module szalu_flags
    import szalu_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 8
) (
    input  alu_sz_e          size,
    input  logic             is_sub,
    input  logic [DW-1:0]    a_op,
    input  logic [DW-1:0]    b_op,
    input  logic [DW-1:0]    sum,
    input  logic [DW/LW-1:0] lane_cout,
    input  logic             x_old,
    input  logic             x_upd,
    output ccr_t             flags
);
    localparam int unsigned LANES = DW / LW;
    localparam int unsigned LIW   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned BW    = $clog2(DW);

    logic [BW-1:0]  msb_idx;
    logic [LIW-1:0] lane_idx;
    logic [DW-1:0]  size_mask;
    logic           sa, sb, sr, cout;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                msb_idx   = BW'(LW - 1);
                lane_idx  = LIW'(0);
                size_mask = DW'({LW{1'b1}});
            end
            SZ_WORD: begin
                msb_idx   = BW'(2*LW - 1);
                lane_idx  = LIW'(1);
                size_mask = DW'({(2*LW){1'b1}});
            end
            default: begin
                msb_idx   = BW'(DW - 1);
                lane_idx  = LIW'(LANES - 1);
                size_mask = {DW{1'b1}};
            end
        endcase
        sa   = a_op[msb_idx];
        sb   = b_op[msb_idx];
        sr   = sum[msb_idx];
        cout = lane_cout[lane_idx];

        flags.n = sr;
        flags.z = ((sum & size_mask) == '0);
        flags.v = (sa == sb) && (sr != sa);
        flags.c = is_sub ? ~cout : cout;
        flags.x = x_upd ? flags.c : x_old;
    end
endmodule

// File: rtl/szalu_merge.sv
`timescale 1ns/1ps
module szalu_merge
    import szalu_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 8
) (
    input  alu_sz_e       size,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] sum,
    output logic [DW-1:0] merged
);
    always_comb begin
        unique case (size)
            SZ_BYTE: merged = {dst[DW-1:LW], sum[LW-1:0]};
            SZ_WORD: merged = {dst[DW-1:2*LW], sum[2*LW-1:0]};
            default: merged = sum;
        endcase
    end
endmodule

// File: rtl/szflag_alu.sv
`timescale 1ns/1ps
module szflag_alu
    import szalu_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_sel,
    input  logic [1:0]    size_sel,
    input  logic [DW-1:0] src_opnd,
    input  logic [DW-1:0] dst_opnd,
    input  logic          x_in,
    input  logic          x_update,
    output logic [DW-1:0] result,
    output logic [4:0]    ccr_out
);
    localparam int unsigned LANES = DW / LW;

    typedef struct packed {
        logic [DW-1:0] res;
        ccr_t          fl;
    } stage_t;

    alu_op_e          op;
    alu_sz_e          sz;
    logic             is_sub;
    logic             cin;
    logic [DW-1:0]    b_op;
    logic [DW-1:0]    sum;
    logic [LANES-1:0] lane_cout;
    logic [DW-1:0]    merged;
    ccr_t             fl_new;
    stage_t           stage_d, stage_q;
    logic             primed_d, primed_q;

    always_comb begin
        op     = alu_op_e'(op_sel);
        sz     = alu_sz_e'(size_sel);
        is_sub = (op == OP_SUB);
        b_op   = is_sub ? ~src_opnd : src_opnd;
        unique case (op)
            OP_SUB:  cin = 1'b1;
            OP_ADDX: cin = x_in;
            default: cin = 1'b0;
        endcase
    end

    szalu_lane_adder #(.DW(DW), .LW(LW)) u_add (
        .a_in(dst_opnd), .b_in(b_op), .c_in(cin),
        .sum(sum), .lane_cout(lane_cout)
    );

    szalu_flags #(.DW(DW), .LW(LW)) u_flags (
        .size(sz), .is_sub(is_sub), .a_op(dst_opnd), .b_op(b_op),
        .sum(sum), .lane_cout(lane_cout), .x_old(x_in),
        .x_upd(x_update), .flags(fl_new)
    );

    szalu_merge #(.DW(DW), .LW(LW)) u_merge (
        .size(sz), .dst(dst_opnd), .sum(sum), .merged(merged)
    );

    always_comb begin
        stage_d.res = merged;
        stage_d.fl  = fl_new;
        primed_d    = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= '0;
            primed_q <= 1'b0;
        end else begin
            stage_q  <= stage_d;
            primed_q <= primed_d;
        end
    end

    assign result  = stage_q.res;
    assign ccr_out = stage_q.fl;

    AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(x_update)) |-> (stage_q.fl.x == stage_q.fl.c)); // R5

    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(x_update)) |-> (stage_q.fl.x == $past(x_in))); // R6

    AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(size_sel) == 2'd0) |-> (stage_q.res[DW-1:LW] == $past(dst_opnd[DW-1:LW]))); // R7

    AST_WORD_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(size_sel) == 2'd1) |-> (stage_q.res[DW-1:2*LW] == $past(dst_opnd[DW-1:2*LW]))); // R7

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(size_sel) == 2'd0) |-> (stage_q.fl.z == (stage_q.res[LW-1:0] == '0))); // R9

    AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(size_sel) == 2'd1) |-> (stage_q.fl.n == stage_q.res[2*LW-1])); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (stage_q == '0)); // R11
endmodule

// File: tb/sim_szflag_alu.sv
`timescale 1ns/1ps
module sim_szflag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic [31:0] src_opnd = '0;
    logic [31:0] dst_opnd = '0;
    logic        x_in = 1'b0;
    logic        x_update = 1'b0;
    logic [31:0] result;
    logic [4:0]  ccr_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    szflag_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .size_sel(size_sel),
        .src_opnd(src_opnd), .dst_opnd(dst_opnd), .x_in(x_in),
        .x_update(x_update), .result(result), .ccr_out(ccr_out)
    );

    // Reference model from the requirements: returns {result, X,N,Z,V,C}
    function automatic logic [36:0] model(input logic [1:0] op, input logic [1:0] sz,
                                          input logic [31:0] dst, input logic [31:0] src,
                                          input logic xi, input logic xu);
        int unsigned w;
        longint unsigned mask, ua, ub, raw, r, ci;
        longint sa, sb, sres, smax, smin;
        logic c, n, z, v, x;
        logic [31:0] res;
        w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        ua   = {32'd0, dst} & mask;
        ub   = {32'd0, src} & mask;
        ci   = (op == 2'd2) ? longint'(xi) : 0;
        sa   = ((ua >> (w - 1)) & 1) != 0 ? longint'(ua) - longint'(64'd1 << w) : longint'(ua);
        sb   = ((ub >> (w - 1)) & 1) != 0 ? longint'(ub) - longint'(64'd1 << w) : longint'(ub);
        smax = longint'((64'd1 << (w - 1)) - 64'd1);
        smin = -smax - 1;
        if (op == 2'd1) begin
            raw  = ua - ub;
            c    = (ua < ub);
            sres = sa - sb;
        end else begin
            raw  = ua + ub + ci;
            c    = ((raw >> w) & 1) != 0;
            sres = sa + sb + longint'(ci);
        end
        r   = raw & mask;
        n   = ((r >> (w - 1)) & 1) != 0;
        z   = (r == 0);
        v   = (sres > smax) || (sres < smin);
        x   = xu ? c : xi;
        res = (dst & ~mask[31:0]) | r[31:0];
        return {res, x, n, z, v, c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] dst,
                         input logic [31:0] src, input logic xi, input logic xu);
        @(negedge clk);
        op_sel = op; size_sel = sz; dst_opnd = dst; src_opnd = src;
        x_in = xi; x_update = xu;
        @(negedge clk);
    endtask

    task automatic run_model(input string req, input logic [1:0] op, input logic [1:0] sz,
                             input logic [31:0] dst, input logic [31:0] src,
                             input logic xi, input logic xu);
        logic [36:0] e;
        apply(op, sz, dst, src, xi, xu);
        e = model(op, sz, dst, src, xi, xu);
        check({req, " result"}, result, e[36:5]);
        check({req, " flags"}, {27'd0, ccr_out}, {27'd0, e[4:0]});
    endtask

    task automatic t_reset;
        apply(2'd0, 2'd2, 32'h1234_5678, 32'h1111_1111, 1'b1, 1'b1);
        check("R11 reset result", result, 32'h0);
        check("R11 reset flags", {27'd0, ccr_out}, 32'h0);
    endtask

    task automatic t_word_example;
        apply(2'd0, 2'd1, 32'd25, 32'd9, 1'b0, 1'b1);
        check("R1 word 25+9", result, 32'd34);
        check("R1 word 25+9 flags", {27'd0, ccr_out}, 32'h0);
    endtask

    task automatic t_carry_sizes; // R4 carry at bit 7, 15, 31
        apply(2'd0, 2'd0, 32'hABCD_00FF, 32'h0000_0001, 1'b0, 1'b1);
        check("R4 byte carry result", result, 32'hABCD_0000);
        check("R4 byte carry flags XZC", {27'd0, ccr_out}, 32'h15);
        apply(2'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b1);
        check("R4 word carry flags", {27'd0, ccr_out}, 32'h15);
        apply(2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1);
        check("R4 long carry result", result, 32'h0);
        check("R4 long carry flags", {27'd0, ccr_out}, 32'h15);
        apply(2'd0, 2'd0, 32'h0000_00FF, 32'h0000_0000, 1'b0, 1'b1);
        check("R4 byte no carry N", {27'd0, ccr_out}, 32'h08);
    endtask

    task automatic t_sub_borrow;
        apply(2'd1, 2'd0, 32'h7700_0005, 32'h0000_0007, 1'b0, 1'b1);
        check("R2 byte 5-7 result", result, 32'h7700_00FE);
        check("R2 byte 5-7 flags XNC", {27'd0, ccr_out}, 32'h19);
        apply(2'd1, 2'd2, 32'd100, 32'd100, 1'b1, 1'b1);
        check("R2 long equal sub Z", {27'd0, ccr_out}, 32'h04);
    endtask

    task automatic t_addx;
        apply(2'd2, 2'd1, 32'h0000_0010, 32'h0000_0020, 1'b1, 1'b0);
        check("R3 addx with X=1", result, 32'h31);
        apply(2'd2, 2'd0, 32'h0000_00FF, 32'h0000_0000, 1'b1, 1'b1);
        check("R3 addx carry chain flags", {27'd0, ccr_out}, 32'h15);
    endtask

    task automatic t_x_hold; // carry and extend hold in the same cycle
        apply(2'd0, 2'd0, 32'h5A5A_A0FF, 32'h0000_0001, 1'b0, 1'b0);
        check("R6 X held low while C set", {27'd0, ccr_out}, 32'h05);
        check("R7 byte upper kept on carry", result, 32'h5A5A_A000);
        apply(2'd0, 2'd1, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0);
        check("R6 X held high while C clear", {27'd0, ccr_out}, 32'h10);
        apply(2'd0, 2'd1, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1);
        check("R5 X follows C clear", {27'd0, ccr_out}, 32'h00);
    endtask

    task automatic t_merge;
        apply(2'd0, 2'd1, 32'hDEAD_FFF0, 32'h0000_0020, 1'b0, 1'b0);
        check("R7 word upper kept", result, 32'hDEAD_0010);
    endtask

    task automatic t_overflow;
        apply(2'd0, 2'd1, 32'h0000_7FFF, 32'h0000_0001, 1'b0, 1'b1);
        check("R10 word pos overflow NV", {27'd0, ccr_out}, 32'h0A);
        apply(2'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b0, 1'b1);
        check("R10 byte neg overflow V", {27'd0, ccr_out}, 32'h02);
        check("R8 byte sub result", result, 32'h0000_007F);
        apply(2'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
        check("R9 long zero with V C X", {27'd0, ccr_out}, 32'h17);
    endtask

    task automatic t_reserved;
        apply(2'd3, 2'd3, 32'h1234_5678, 32'h1111_1111, 1'b1, 1'b1);
        check("R12 op3 size3 as long add", result, 32'h2345_6789);
        check("R12 op3 ignores X", {27'd0, ccr_out}, 32'h00);
    endtask

    task automatic t_sweep;
        logic [31:0] lf = 32'hACE1_2468;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a, b;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b  = lf ^ {lf[15:0], lf[31:16]};
            run_model("R1 R2 R3 R8 R9 R10 sweep", lf[1:0], lf[3:2], a, b, lf[4], lf[5]);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_word_example();
        t_carry_sizes();
        t_sub_borrow();
        t_addx();
        t_x_hold();
        t_merge();
        t_overflow();
        t_reserved();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule